// File: doc/BRIEF.md
# Eight-bit ALU with NZCV flag register

This block is the arithmetic and logic datapath of a small 8-bit accumulator processor. One operation code chooses among add with carry, subtract with borrow, AND, OR, XOR, compare, bit test, shift and rotate in both directions, increment, decrement and load. Each operation acts on a register operand (the accumulator), a memory operand and the carry-in. The result byte and the next values of the negative, zero, carry and overflow flags appear combinationally in the same cycle. A per-flag enable mask shows which flags the operation may change.

The block holds the four flags in a register. On a clock edge with `valid_i` high, the register loads the merged next-flag value. A disabled flag keeps its old value. The result byte is not stored: the surrounding core decides where it goes. All arithmetic is binary, and a decimal mode is never consulted. Subtract and compare share the adder with addition: they invert the memory operand. Shift, rotate, increment, decrement and load all act on the memory operand.

Top module: `alu8_nzcv`

## Requirements
- R1: Operation code 0 (add) forms the 9-bit sum acc + opnd + carry_i. The result is the low byte, C is bit 8, and V is bit 7 of (acc XOR sum) AND (opnd XOR sum). All four flags are enabled.
- R2: Operation code 1 (subtract) is the add of R1 with the operand bitwise inverted and carry_i as the carry-in. The result and all four flags follow R1 on the inverted operand.
- R3: Operation code 5 (compare) evaluates acc minus opnd in 9 bits. C is 1 exactly when acc >= opnd (unsigned). N is bit 7 of the difference, and Z is 1 when the low byte of the difference is zero. res_o equals acc_i, and V is left unchanged.
- R4: Operation code 6 (bit test) sets N from opnd bit 7 and V from opnd bit 6. Z is 1 when (acc AND opnd) is zero. C is left unchanged and res_o equals acc_i.
- R5: Operation codes 2 (AND), 3 (OR), 4 (XOR) and 13 (load opnd) return the logic result or the operand. N is bit 7 of the result and Z is 1 when the result is zero. C and V are left unchanged.
- R6: Operation codes 7 (shift left) and 8 (shift right) shift opnd by one place with a zero fill. The bit shifted out goes to C, N and Z follow the result, and V is left unchanged.
- R7: Operation codes 9 (rotate left) and 10 (rotate right) behave like R6, except that carry_i fills the vacated end.
- R8: Operation codes 11 (increment) and 12 (decrement) add or subtract one from opnd, wrapping modulo 256. N and Z follow the result, and C and V are left unchanged.
- R9: flag_en_o and nzcv_o use the bit order N=3, Z=2, C=1, V=0. flags_o resets to 0000. On a clock edge with valid_i high it loads nzcv_o. With valid_i low it holds its value.
- R10: Operation codes 14 and 15 are reserved. Their mask is 0000, res_o equals acc_i and nzcv_o equals flags_o.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Commit the flag update at this edge |
| op_i | input | 4 | Operation code |
| acc_i | input | 8 | Register (accumulator) operand |
| opnd_i | input | 8 | Memory operand |
| carry_i | input | 1 | Carry-in for add, subtract and rotate |
| res_o | output | 8 | Result byte, combinational |
| nzcv_o | output | 4 | Next flag values, with disabled flags merged from flags_o |
| flag_en_o | output | 4 | Flags this operation changes |
| flags_o | output | 4 | Flag register |

## Verification
res_o, flag_en_o and nzcv_o are combinational, so each vector is checked 1 ns after its inputs change at a falling edge, in the same cycle. flags_o is due one rising edge later. The bench samples it 1 ns after that edge and compares it with the value it tracks itself. Hold behaviour with valid_i low, and the asynchronous clear, are checked at the same offsets after the edge or the reset that should, or should not, change them.

// File: rtl/alu8_pkg.sv
package alu8_pkg;
  typedef enum logic [3:0] {
    OP_ADC = 4'd0,
    OP_SBC = 4'd1,
    OP_AND = 4'd2,
    OP_ORA = 4'd3,
    OP_EOR = 4'd4,
    OP_CMP = 4'd5,
    OP_BIT = 4'd6,
    OP_ASL = 4'd7,
    OP_LSR = 4'd8,
    OP_ROL = 4'd9,
    OP_ROR = 4'd10,
    OP_INC = 4'd11,
    OP_DEC = 4'd12,
    OP_LDA = 4'd13,
    OP_RS0 = 4'd14,
    OP_RS1 = 4'd15
  } alu_op_e;

  localparam int unsigned FLAG_N = 3;
  localparam int unsigned FLAG_Z = 2;
  localparam int unsigned FLAG_C = 1;
  localparam int unsigned FLAG_V = 0;
  localparam int unsigned NFLAGS = 4;
endpackage

// File: rtl/alu8_addsub.sv
module alu8_addsub #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         inv_i,
  input  logic         cin_i,
  output logic [W-1:0] sum_o,
  output logic         cout_o,
  output logic         ovf_o
);
  localparam int unsigned WS = W + 1;

  logic [W-1:0]  b_eff;
  logic [WS-1:0] full;

  assign b_eff  = inv_i ? ~b_i : b_i;
  assign full   = {1'b0, a_i} + {1'b0, b_eff} + {{W{1'b0}}, cin_i};
  assign sum_o  = full[W-1:0];
  assign cout_o = full[W];
  // signed overflow: both inputs disagree in sign with the sum
  assign ovf_o  = (a_i[W-1] ^ full[W-1]) & (b_eff[W-1] ^ full[W-1]);
endmodule

// File: rtl/alu8_shift.sv
module alu8_shift #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] in_i,
  input  logic         cin_i,
  input  logic         left_i,
  input  logic         rot_i,
  output logic [W-1:0] out_o,
  output logic         cout_o
);
  logic fill;

  assign fill = rot_i & cin_i;

  always_comb begin
    if (left_i) begin
      out_o  = {in_i[W-2:0], fill};
      cout_o = in_i[W-1];
    end else begin
      out_o  = {fill, in_i[W-1:1]};
      cout_o = in_i[0];
    end
  end
endmodule

// File: rtl/alu8_logic.sv
module alu8_logic
  import alu8_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  alu_op_e      op_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] out_o
);
  localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

  always_comb begin
    case (op_i)
      OP_AND:  out_o = a_i & b_i;
      OP_ORA:  out_o = a_i | b_i;
      OP_EOR:  out_o = a_i ^ b_i;
      OP_INC:  out_o = b_i + ONE;
      OP_DEC:  out_o = b_i - ONE;
      default: out_o = b_i;
    endcase
  end
endmodule

// File: rtl/alu8_nzcv.sv
module alu8_nzcv
  import alu8_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [3:0]        op_i,
  input  logic [W-1:0]      acc_i,
  input  logic [W-1:0]      opnd_i,
  input  logic              carry_i,
  output logic [W-1:0]      res_o,
  output logic [NFLAGS-1:0] nzcv_o,
  output logic [NFLAGS-1:0] flag_en_o,
  output logic [NFLAGS-1:0] flags_o
);
  localparam logic [NFLAGS-1:0] EN_ALL   = 4'b1111;
  localparam logic [NFLAGS-1:0] EN_NZC   = 4'b1110;
  localparam logic [NFLAGS-1:0] EN_NZV   = 4'b1101;
  localparam logic [NFLAGS-1:0] EN_NZ    = 4'b1100;
  localparam logic [NFLAGS-1:0] EN_NONE  = 4'b0000;

  alu_op_e           op;
  logic              is_sub, is_cmp, sh_left, sh_rot;
  logic [W-1:0]      sum, sh_out, lg_out;
  logic              sum_c, sum_v, sh_c;
  logic [NFLAGS-1:0] flags_q, raw;

  assign op      = alu_op_e'(op_i);
  assign is_cmp  = (op == OP_CMP);
  assign is_sub  = (op == OP_SBC) | is_cmp;
  assign sh_left = (op == OP_ASL) | (op == OP_ROL);
  assign sh_rot  = (op == OP_ROL) | (op == OP_ROR);

  // compare is a subtract with no incoming borrow
  alu8_addsub #(.W(W)) u_addsub (
    .a_i   (acc_i),
    .b_i   (opnd_i),
    .inv_i (is_sub),
    .cin_i (is_cmp | carry_i),
    .sum_o (sum),
    .cout_o(sum_c),
    .ovf_o (sum_v)
  );

  alu8_shift #(.W(W)) u_shift (
    .in_i  (opnd_i),
    .cin_i (carry_i),
    .left_i(sh_left),
    .rot_i (sh_rot),
    .out_o (sh_out),
    .cout_o(sh_c)
  );

  alu8_logic #(.W(W)) u_logic (
    .op_i (op),
    .a_i  (acc_i),
    .b_i  (opnd_i),
    .out_o(lg_out)
  );

  always_comb begin
    res_o     = acc_i;
    raw       = flags_q;
    flag_en_o = EN_NONE;
    case (op)
      OP_ADC, OP_SBC: begin
        res_o     = sum;
        raw       = {sum[W-1], sum == '0, sum_c, sum_v};
        flag_en_o = EN_ALL;
      end
      OP_CMP: begin
        raw       = {sum[W-1], sum == '0, sum_c, flags_q[FLAG_V]};
        flag_en_o = EN_NZC;
      end
      OP_BIT: begin
        raw       = {opnd_i[W-1], (acc_i & opnd_i) == '0, flags_q[FLAG_C], opnd_i[W-2]};
        flag_en_o = EN_NZV;
      end
      OP_AND, OP_ORA, OP_EOR, OP_LDA, OP_INC, OP_DEC: begin
        res_o     = lg_out;
        raw       = {lg_out[W-1], lg_out == '0, flags_q[FLAG_C], flags_q[FLAG_V]};
        flag_en_o = EN_NZ;
      end
      OP_ASL, OP_LSR, OP_ROL, OP_ROR: begin
        res_o     = sh_out;
        raw       = {sh_out[W-1], sh_out == '0, sh_c, flags_q[FLAG_V]};
        flag_en_o = EN_NZC;
      end
      default: ;
    endcase
  end

  assign nzcv_o = (raw & flag_en_o) | (flags_q & ~flag_en_o);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      flags_q <= '0;
    else if (valid_i) flags_q <= nzcv_o;
  end

  assign flags_o = flags_q;

  p_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(flags_o));

  p_masked_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> ((flags_o & ~$past(flag_en_o)) == ($past(flags_o) & ~$past(flag_en_o))));

  p_cmp_nb_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op == OP_CMP) |-> (nzcv_o[FLAG_C] == (acc_i >= opnd_i)));

  p_bit_nv_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op == OP_BIT) |-> (nzcv_o[FLAG_N] == opnd_i[W-1] && nzcv_o[FLAG_V] == opnd_i[W-2]));

  p_logic_z_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op inside {OP_AND, OP_ORA, OP_EOR, OP_LDA}) |-> (nzcv_o[FLAG_Z] == (res_o == '0)));

  p_rot_keep_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sh_rot |-> ($countones({nzcv_o[FLAG_C], res_o}) == $countones({carry_i, opnd_i})));

  p_incdec_cv_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op inside {OP_INC, OP_DEC}) |-> (nzcv_o[1:0] == flags_o[1:0]));

  p_rsv_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op inside {OP_RS0, OP_RS1}) |-> (nzcv_o == flags_o && res_o == acc_i));
endmodule

// File: tb/alu8_nzcv_bench.sv
module alu8_nzcv_bench;
  localparam int NV = 27;
  // {op, acc, opnd, cin, res, nzcv(raw, masked by en), en}
  localparam logic [36:0] VEC [NV] = '{
    {4'd0,  8'h50, 8'h50, 1'b0, 8'hA0, 4'b1001, 4'b1111},
    {4'd0,  8'hFF, 8'h01, 1'b0, 8'h00, 4'b0110, 4'b1111},
    {4'd0,  8'h7F, 8'h00, 1'b1, 8'h80, 4'b1001, 4'b1111},
    {4'd1,  8'h50, 8'hF0, 1'b1, 8'h60, 4'b0000, 4'b1111},
    {4'd1,  8'h50, 8'hB0, 1'b1, 8'hA0, 4'b1001, 4'b1111},
    {4'd1,  8'h05, 8'h03, 1'b0, 8'h01, 4'b0010, 4'b1111},
    {4'd5,  8'h40, 8'h40, 1'b0, 8'h40, 4'b0110, 4'b1110},
    {4'd5,  8'h10, 8'h20, 1'b1, 8'h10, 4'b1000, 4'b1110},
    {4'd5,  8'h20, 8'h10, 1'b0, 8'h20, 4'b0010, 4'b1110},
    {4'd6,  8'h0F, 8'hC0, 1'b0, 8'h0F, 4'b1101, 4'b1101},
    {4'd6,  8'h41, 8'h01, 1'b1, 8'h41, 4'b0000, 4'b1101},
    {4'd2,  8'hF0, 8'h3C, 1'b0, 8'h30, 4'b0000, 4'b1100},
    {4'd3,  8'h00, 8'h00, 1'b0, 8'h00, 4'b0100, 4'b1100},
    {4'd4,  8'hFF, 8'h0F, 1'b0, 8'hF0, 4'b1000, 4'b1100},
    {4'd13, 8'h11, 8'h80, 1'b0, 8'h80, 4'b1000, 4'b1100},
    {4'd13, 8'h11, 8'h00, 1'b1, 8'h00, 4'b0100, 4'b1100},
    {4'd7,  8'h00, 8'h81, 1'b1, 8'h02, 4'b0010, 4'b1110},
    {4'd8,  8'h00, 8'h01, 1'b1, 8'h00, 4'b0110, 4'b1110},
    {4'd9,  8'h00, 8'h80, 1'b1, 8'h01, 4'b0010, 4'b1110},
    {4'd10, 8'h00, 8'h01, 1'b1, 8'h80, 4'b1010, 4'b1110},
    {4'd10, 8'h00, 8'h02, 1'b0, 8'h01, 4'b0000, 4'b1110},
    {4'd0,  8'h7F, 8'h01, 1'b0, 8'h80, 4'b1001, 4'b1111},
    {4'd11, 8'h00, 8'hFF, 1'b0, 8'h00, 4'b0100, 4'b1100},
    {4'd12, 8'h00, 8'h00, 1'b1, 8'hFF, 4'b1000, 4'b1100},
    {4'd11, 8'h00, 8'h7F, 1'b0, 8'h80, 4'b1000, 4'b1100},
    {4'd14, 8'h5A, 8'h33, 1'b1, 8'h5A, 4'b0000, 4'b0000},
    {4'd15, 8'hA5, 8'hFF, 1'b0, 8'hA5, 4'b0000, 4'b0000}
  };

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       valid_i = 1'b0;
  logic [3:0] op_i = '0;
  logic [7:0] acc_i = '0;
  logic [7:0] opnd_i = '0;
  logic       carry_i = 1'b0;
  logic [7:0] res_o;
  logic [3:0] nzcv_o, flag_en_o, flags_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;
  logic [3:0] exp_flags;

  always #4 clk_i = ~clk_i;

  alu8_nzcv u_alu8_nzcv (
    .clk_i, .rst_ni, .valid_i, .op_i, .acc_i, .opnd_i, .carry_i,
    .res_o, .nzcv_o, .flag_en_o, .flags_o
  );

  function automatic string tag(input logic [3:0] op);
    case (op)
      4'd0:                      return "R1";
      4'd1:                      return "R2";
      4'd5:                      return "R3";
      4'd6:                      return "R4";
      4'd2, 4'd3, 4'd4, 4'd13:   return "R5";
      4'd7, 4'd8:                return "R6";
      4'd9, 4'd10:               return "R7";
      4'd11, 4'd12:              return "R8";
      default:                   return "R10";
    endcase
  endfunction

  task automatic chk(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      n_bad++;
      $display("FAIL R9 watchdog: actual hung expected done");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    exp_flags = '0;
    repeat (2) @(negedge clk_i);
    #1 chk("R9", "reset flags", {4'h0, flags_o}, 8'h00);
    @(negedge clk_i) rst_ni = 1'b1;

    for (int i = 0; i < NV; i++) begin
      logic [3:0] v_op, v_nzcv, v_en, v_next;
      logic [7:0] v_acc, v_opnd, v_res;
      logic       v_cin;
      {v_op, v_acc, v_opnd, v_cin, v_res, v_nzcv, v_en} = VEC[i];
      @(negedge clk_i);
      op_i = v_op; acc_i = v_acc; opnd_i = v_opnd; carry_i = v_cin; valid_i = 1'b1;
      v_next = (v_nzcv & v_en) | (exp_flags & ~v_en);
      #1;
      chk(tag(v_op), "result", res_o, v_res);
      chk(tag(v_op), "mask", {4'h0, flag_en_o}, {4'h0, v_en});
      chk(tag(v_op), "next flags", {4'h0, nzcv_o}, {4'h0, v_next});
      @(posedge clk_i);
      #1 chk("R9", "flag reg", {4'h0, flags_o}, {4'h0, v_next});
      exp_flags = v_next;
    end

    // R9: with valid low an add that would change flags is not committed
    @(negedge clk_i);
    op_i = 4'd0; acc_i = 8'hFF; opnd_i = 8'hFF; carry_i = 1'b1; valid_i = 1'b0;
    @(posedge clk_i);
    #1 chk("R9", "hold no valid", {4'h0, flags_o}, {4'h0, exp_flags});
    @(posedge clk_i);
    #1 chk("R9", "hold 2nd edge", {4'h0, flags_o}, {4'h0, exp_flags});

    // R8: carry and overflow kept when set before an increment
    @(negedge clk_i);
    op_i = 4'd0; acc_i = 8'h80; opnd_i = 8'h80; carry_i = 1'b0; valid_i = 1'b1;
    @(posedge clk_i);
    #1 chk("R1", "C V set", {4'h0, flags_o}, 8'h07);
    @(negedge clk_i);
    op_i = 4'd11; opnd_i = 8'h10;
    @(posedge clk_i);
    #1 chk("R8", "inc keeps C V", {4'h0, flags_o}, 8'h03);

    // R9: asynchronous clear mid-run
    @(negedge clk_i);
    valid_i = 1'b0;
    rst_ni = 1'b0;
    #1 chk("R9", "async clear", {4'h0, flags_o}, 8'h00);
    @(negedge clk_i) rst_ni = 1'b1;

    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule